// File: doc/BRIEF.md
# Voltage-Code Debounce and Slew Controller

This block watches an 8-bit voltage-identification code and moves an internal reference DAC code toward each newly requested value at a fixed, bounded rate. The input is read only on a one-cycle sample tick of the system clock. A code counts as requested only after it has read the same on several consecutive ticks. The DAC code then walks one LSB at a time, with one step for every few sample ticks, until it equals the request. Because of this, the time a transition takes depends only on the size of the code difference.

A small set of reserved codes means "stop regulating". These codes need a longer run of identical samples before they count. Once one is recognised, regulation is latched off and stays off until the enable input is taken low and raised again. After reset, or while enable is low, the block holds no valid code. The first normal code that qualifies with enable high is loaded straight into the DAC, with no stepping.

Top module: `vid_slew_ctrl`

## Requirements
- R1: While reset is held and after its release, before any tick, `dac_code` is 0x00 and `reg_on` and `busy` are low.
- R2: The reserved off codes are 0x00, 0x01, 0xFE and 0xFF. A normal code is accepted on the tick that gives its third consecutive identical sample; with fewer identical samples nothing happens.
- R3: A sample that differs from the previous sample restarts the run of identical samples at one.
- R4: With enable high and no code yet held, the first accepted normal code is loaded directly into `dac_code`. On that same tick `reg_on` goes high and `busy` stays low.
- R5: When the accepted code differs from `dac_code`, `busy` is high. `dac_code` then moves by exactly one toward the accepted code on every third sample tick, with the first step three ticks after acceptance. `busy` falls on the tick the two become equal. `dac_code` never changes on a clock without a tick.
- R6: A code accepted while stepping becomes the new goal, and stepping goes on from the present `dac_code` with no jump. If acceptance falls on a step tick, that step already moves toward the new goal.
- R7: An off code is recognised on its fourth consecutive identical sample, and three samples are not enough. On recognition `reg_on` and `busy` drop, and `dac_code` freezes, even in the middle of a step sequence. While regulating, `dac_code` is never an off code.
- R8: While latched off with enable high, normal codes that qualify are ignored, and `dac_code` and `reg_on` do not change.
- R9: With enable low, `reg_on` and `busy` are low, `dac_code` holds its value and the off latch clears. After enable returns high, the next qualifying normal code is loaded as in R4.
- R10: While regulating, `dac_code` changes by at most one between consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle sample strobe; the code is read only when high |
| enable | input | 1 | Regulation enable; a low period clears the off latch |
| vid_in | input | 8 | Requested voltage-identification code |
| dac_code | output | 8 | Present reference DAC code |
| reg_on | output | 1 | High while regulation is active |
| busy | output | 1 | High while `dac_code` is stepping toward the accepted code |

## Verification
Two functions can fall in the same cycle: accepting a new code, and the step tick of a sequence already under way. The bench times a reversal so that the third identical sample of the new code lands exactly on a step tick. It expects `dac_code` to move one LSB toward the new goal on that tick, not toward the old one. A second case sends an off code while a step is pending. The bench then expects `dac_code` to stay frozen at its last value while `reg_on` and `busy` fall.

// File: rtl/vid_slew_pkg.sv
package vid_slew_pkg;

   // Tracker state: no code held yet, regulating, or latched off
   typedef enum logic [1:0] {
      TRK_WAIT = 2'd0,
      TRK_REG  = 2'd1,
      TRK_OFF  = 2'd2
   } trk_state_e;

   // Counter width needed to hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/vid_sampler.sv
module vid_sampler #(
   parameter int VID_W        = 8,
   parameter int NORM_SAMPLES = 3,
   parameter int OFF_SAMPLES  = 4,
   parameter int OFF_LO_MAX   = 1,
   parameter int OFF_HI_CNT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_tick,
   input  logic [VID_W-1:0] vid_in,
   output logic             qual_norm,
   output logic             qual_off
);
   import vid_slew_pkg::*;

   localparam int CNT_MAX = (OFF_SAMPLES > NORM_SAMPLES) ? OFF_SAMPLES : NORM_SAMPLES;
   localparam int CNT_W   = cnt_width(CNT_MAX);
   localparam logic [VID_W:0] OFF_HI_MIN = (VID_W+1)'((1 << VID_W) - OFF_HI_CNT);
   localparam logic [VID_W:0] OFF_LO_LIM = (VID_W+1)'(OFF_LO_MAX);

   logic [VID_W-1:0] last_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_nxt;
   logic             same;
   logic             is_off;

   assign same = (run_q != '0) && (vid_in == last_q);

   always_comb begin
      if (!same)
         run_nxt = CNT_W'(1);
      else if (run_q == CNT_W'(CNT_MAX))
         run_nxt = run_q;
      else
         run_nxt = run_q + CNT_W'(1);
   end

   // Reserved codes sit at both ends of the code range
   generate
      if (OFF_HI_CNT > 0) begin : g_off_hi
         assign is_off = ({1'b0, vid_in} <= OFF_LO_LIM) ||
                         ({1'b0, vid_in} >= OFF_HI_MIN);
      end else begin : g_off_lo
         assign is_off = ({1'b0, vid_in} <= OFF_LO_LIM);
      end
   endgenerate

   assign qual_norm = sample_tick && !is_off && (run_nxt >= CNT_W'(NORM_SAMPLES));
   assign qual_off  = sample_tick &&  is_off && (run_nxt >= CNT_W'(OFF_SAMPLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         run_q  <= '0;
      end else if (sample_tick) begin
         last_q <= vid_in;
         run_q  <= run_nxt;
      end
   end

endmodule

// File: rtl/vid_step_timer.sv
module vid_step_timer #(
   parameter int STEP_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_tick,
   input  logic run,
   output logic step_now
);
   import vid_slew_pkg::*;

   generate
      if (STEP_DIV == 1) begin : g_every_tick
         assign step_now = sample_tick && run;
      end else begin : g_divided
         localparam int PH_W = cnt_width(STEP_DIV - 1);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_DIV - 1);
         logic [PH_W-1:0] phase_q;

         assign step_now = sample_tick && run && (phase_q == PH_LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (sample_tick) begin
               if (!run || phase_q == PH_LAST)
                  phase_q <= '0;
               else
                  phase_q <= phase_q + PH_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vid_dac_tracker.sv
module vid_dac_tracker #(
   parameter int VID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             qual_norm,
   input  logic             qual_off,
   input  logic [VID_W-1:0] code,
   input  logic             step_now,
   output logic [VID_W-1:0] dac_q,
   output logic [VID_W-1:0] goal_nxt,
   output vid_slew_pkg::trk_state_e state_q
);
   import vid_slew_pkg::*;

   logic [VID_W-1:0] goal_q;

   assign goal_nxt = (state_q == TRK_REG && qual_norm) ? code : goal_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_WAIT;
         dac_q   <= '0;
         goal_q  <= '0;
      end else if (!enable) begin
         state_q <= TRK_WAIT;
      end else begin
         unique case (state_q)
            TRK_WAIT: begin
               if (qual_off)
                  state_q <= TRK_OFF;
               else if (qual_norm) begin
                  dac_q   <= code;
                  goal_q  <= code;
                  state_q <= TRK_REG;
               end
            end
            TRK_REG: begin
               if (qual_off)
                  state_q <= TRK_OFF;
               else begin
                  goal_q <= goal_nxt;
                  if (step_now) begin
                     if (goal_nxt > dac_q)
                        dac_q <= dac_q + VID_W'(1);
                     else if (goal_nxt < dac_q)
                        dac_q <= dac_q - VID_W'(1);
                  end
               end
            end
            default: state_q <= TRK_OFF;
         endcase
      end
   end

endmodule

// File: rtl/vid_slew_ctrl.sv
module vid_slew_ctrl #(
   parameter int VID_W        = 8,
   parameter int NORM_SAMPLES = 3,
   parameter int OFF_SAMPLES  = 4,
   parameter int STEP_DIV     = 3,
   parameter int OFF_LO_MAX   = 1,
   parameter int OFF_HI_CNT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_tick,
   input  logic             enable,
   input  logic [VID_W-1:0] vid_in,
   output logic [VID_W-1:0] dac_code,
   output logic             reg_on,
   output logic             busy
);
   import vid_slew_pkg::*;

   generate
      if (VID_W < 3)
         $error("vid_slew_ctrl: VID_W must be at least 3");
      if (NORM_SAMPLES < 1)
         $error("vid_slew_ctrl: NORM_SAMPLES must be at least 1");
      if (OFF_SAMPLES < 1)
         $error("vid_slew_ctrl: OFF_SAMPLES must be at least 1");
      if (STEP_DIV < 1)
         $error("vid_slew_ctrl: STEP_DIV must be at least 1");
      if (OFF_LO_MAX < 0 || OFF_HI_CNT < 0)
         $error("vid_slew_ctrl: off-code span must not be negative");
      if (OFF_LO_MAX + 1 + OFF_HI_CNT >= (1 << VID_W))
         $error("vid_slew_ctrl: off codes leave no normal code");
   endgenerate

   logic             qual_norm;
   logic             qual_off;
   logic             step_now;
   logic             run;
   logic             latched_off;
   logic [VID_W-1:0] goal_nxt;
   logic [VID_W-1:0] dac_q;
   trk_state_e       state_q;

   vid_sampler #(
      .VID_W        (VID_W),
      .NORM_SAMPLES (NORM_SAMPLES),
      .OFF_SAMPLES  (OFF_SAMPLES),
      .OFF_LO_MAX   (OFF_LO_MAX),
      .OFF_HI_CNT   (OFF_HI_CNT)
   ) u_samp (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .vid_in      (vid_in),
      .qual_norm   (qual_norm),
      .qual_off    (qual_off)
   );

   // Phase runs only while a step sequence was already pending before this tick
   assign run = busy && (dac_q != goal_nxt);

   vid_step_timer #(
      .STEP_DIV (STEP_DIV)
   ) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .run         (run),
      .step_now    (step_now)
   );

   vid_dac_tracker #(
      .VID_W (VID_W)
   ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .qual_norm (qual_norm),
      .qual_off  (qual_off),
      .code      (vid_in),
      .step_now  (step_now),
      .dac_q     (dac_q),
      .goal_nxt  (goal_nxt),
      .state_q   (state_q)
   );

   assign dac_code    = dac_q;
   assign reg_on      = (state_q == TRK_REG);
   assign latched_off = (state_q == TRK_OFF);
   assign busy        = reg_on && (dac_q != u_trk.goal_q);

endmodule

// File: rtl/vid_slew_ctrl_chk.sv
module vid_slew_ctrl_chk #(
   parameter int VID_W      = 8,
   parameter int OFF_LO_MAX = 1,
   parameter int OFF_HI_CNT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_tick,
   input logic             enable,
   input logic [VID_W-1:0] dac_code,
   input logic             reg_on,
   input logic             busy,
   input logic             latched_off
);
   localparam logic [VID_W:0] HI_MIN = (VID_W+1)'((1 << VID_W) - OFF_HI_CNT);
   localparam logic [VID_W:0] LO_LIM = (VID_W+1)'(OFF_LO_MAX);

   // R1: reset clears the outputs
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (dac_code == '0 && !reg_on && !busy));

   // R5: the DAC code moves only on a sample tick
   p_tick_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(dac_code));

   // R5: stepping only happens while regulating
   p_busy_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> reg_on);

   // R10: no jump larger than one LSB while regulating
   p_one_lsb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_on && $past(reg_on)) |->
         (dac_code == $past(dac_code) ||
          dac_code == $past(dac_code) + VID_W'(1) ||
          dac_code == $past(dac_code) - VID_W'(1)));

   // R7: a regulating DAC code is never a reserved code
   p_no_off_dac_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_on |-> ({1'b0, dac_code} > LO_LIM && {1'b0, dac_code} < HI_MIN));

   // R7: the latch forces regulation and stepping off
   p_latch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      latched_off |-> (!reg_on && !busy));

   // R8: latched with enable high, the code is frozen and the latch holds
   p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_off && enable) |=> (latched_off && $stable(dac_code)));

   // R9: enable low stops regulation on the next clock
   p_enable_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!reg_on && !latched_off));

endmodule

bind vid_slew_ctrl vid_slew_ctrl_chk #(
   .VID_W      (VID_W),
   .OFF_LO_MAX (OFF_LO_MAX),
   .OFF_HI_CNT (OFF_HI_CNT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_tick (sample_tick),
   .enable      (enable),
   .dac_code    (dac_code),
   .reg_on      (reg_on),
   .busy        (busy),
   .latched_off (latched_off)
);

// File: tb/vid_slew_ctrl_tb.sv
`timescale 1ns/1ps
module vid_slew_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b0;
   logic       enable = 1'b0;
   logic [7:0] vid_in = 8'h00;
   logic [7:0] dac_code;
   logic       reg_on;
   logic       busy;

   always #2.5 clk = ~clk;

   vid_slew_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .enable      (enable),
      .vid_in      (vid_in),
      .dac_code    (dac_code),
      .reg_on      (reg_on),
      .busy        (busy)
   );

   typedef struct {
      int         tk;
      logic [7:0] dac;
      logic       on;
      logic       bsy;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   drv_tk = 0;
   int   mon_tk = 0;
   bit   done = 1'b0;

   task automatic compare(string tag, logic [7:0] d, logic on, logic b);
      n_cmp++;
      if (dac_code !== d || reg_on !== on || busy !== b) begin
         n_bad++;
         $display("FAIL %s: dac=%02h reg_on=%0b busy=%0b expected dac=%02h reg_on=%0b busy=%0b",
                  tag, dac_code, reg_on, busy, d, on, b);
      end
   endtask

   // Driver side: queue the expected outputs after a given tick
   task automatic expect_at(int tk, logic [7:0] d, logic on, logic b, string tag);
      exp_t e;
      e.tk = tk; e.dac = d; e.on = on; e.bsy = b; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic tick();
      @(negedge clk) sample_tick = 1'b1;
      @(negedge clk) sample_tick = 1'b0;
      repeat (2) @(negedge clk);
      drv_tk++;
   endtask

   task automatic drive(logic [7:0] v, int n);
      vid_in = v;
      for (int i = 0; i < n; i++) tick();
   endtask

   // Monitor: after every tick edge, compare the items due for that tick
   initial begin
      forever begin
         @(posedge clk);
         if (sample_tick) begin
            #2;
            mon_tk++;
            while (exp_q.size() > 0 && exp_q[0].tk == mon_tk) begin
               exp_t e;
               e = exp_q.pop_front();
               compare(e.tag, e.dac, e.on, e.bsy);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset held", 8'h00, 1'b0, 1'b0);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);
      compare("R1 after release", 8'h00, 1'b0, 1'b0);

      // R2/R4: first accepted code loads directly
      expect_at(2,  8'h00, 0, 0, "R2 two samples only");
      expect_at(3,  8'h40, 1, 0, "R4 direct load on third sample");
      expect_at(5,  8'h40, 1, 0, "R2 repeat of held code");
      // R5: upward slew
      expect_at(8,  8'h40, 1, 1, "R5 accepted, busy");
      expect_at(10, 8'h40, 1, 1, "R5 no step before third tick");
      expect_at(11, 8'h41, 1, 1, "R5 first step");
      expect_at(14, 8'h42, 1, 1, "R5 second step");
      expect_at(20, 8'h44, 1, 0, "R5 reached goal");
      // R3: glitch restarts the run
      expect_at(25, 8'h44, 1, 0, "R3 run restarted by glitch");
      expect_at(26, 8'h44, 1, 1, "R3 accepted after restart");
      expect_at(29, 8'h43, 1, 1, "R5 downward step");
      expect_at(32, 8'h42, 1, 1, "R5 downward step two");
      // R6: acceptance on a step tick
      expect_at(35, 8'h43, 1, 1, "R6 step toward new goal");
      expect_at(41, 8'h45, 1, 1, "R6 continuing");
      expect_at(44, 8'h46, 1, 0, "R6 reached new goal");
      // R7/R8: off code latch
      expect_at(47, 8'h46, 1, 0, "R7 three off samples not enough");
      expect_at(48, 8'h46, 0, 0, "R7 latched on fourth sample");
      expect_at(52, 8'h46, 0, 0, "R8 normal code ignored");
      // R9: enable toggle
      expect_at(53, 8'h46, 0, 0, "R9 enable low");
      expect_at(54, 8'h20, 1, 0, "R9 reload after enable");
      expect_at(57, 8'h20, 1, 0, "R7 off code run of three");
      expect_at(60, 8'h20, 1, 1, "R2 accepted 0x22");
      expect_at(63, 8'h21, 1, 1, "R5 step toward 0x22");
      expect_at(64, 8'h21, 0, 0, "R7 off code freezes mid slew");
      expect_at(67, 8'h21, 0, 0, "R9 no load while disabled");
      expect_at(68, 8'h50, 1, 0, "R9 load after enable rise");

      drive(8'h40, 5);    // ticks 1-5
      drive(8'h44, 15);   // 6-20
      drive(8'h30, 2);    // 21-22
      drive(8'h31, 1);    // 23
      drive(8'h30, 9);    // 24-32
      drive(8'h46, 12);   // 33-44
      drive(8'hFF, 4);    // 45-48
      drive(8'h20, 4);    // 49-52
      enable = 1'b0;
      drive(8'h20, 1);    // 53
      enable = 1'b1;
      drive(8'h20, 1);    // 54
      drive(8'h01, 3);    // 55-57
      drive(8'h22, 3);    // 58-60
      drive(8'h00, 4);    // 61-64
      enable = 1'b0;
      drive(8'h50, 3);    // 65-67
      enable = 1'b1;
      drive(8'h50, 1);    // 68

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R5 pending items: actual=%0d expected=0", exp_q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule